// File: doc/BRIEF.md
# Stride-Trained Prefetch Read Engine

This block sits between cache-line read requesters and a memory port. Software arms it with one configuration write, which sets a training flag, loads a request limit, and picks a seed depth of two or three lines. Once armed, the engine looks for a run of reads to strictly consecutive lines inside one 4 KB page. When the run reaches the seed depth, the engine fetches a window of lines starting at the first seed line. The window holds the limit plus one lines, and it is cut short at the end of the page. The fetched lines go into a local line buffer.

The training flag stays set until every line of the window has been filled. The flag then drops by itself, and software takes that as the sign that training is over. From then on, reads that land on a buffered line are answered from the buffer one cycle later and never reach memory. Every other read goes to the memory port unchanged. This includes reads made during training and reads outside the window. Demand responses for those reads return to the requester along a path outside this block. The block receives only prefetch fills back.

Top module: `pfe_engine`

## Requirements
- R1: After reset the training flag is 0, and no memory request or buffer hit is presented.
- R2: A configuration write sets the training flag on the next cycle and invalidates every buffered line. A later read of a line held before the write misses, even when the line falls inside the new window.
- R3: Prefetching starts only once the selected number of seed reads has been seen in a row: two when the seed-depth input is 0, three when it is 1.
- R4: During seeding, a read that is not exactly one line above the previous seed restarts the count and becomes the new first seed. The window then starts at that read.
- R5: Two reads in different 4 KB pages are never consecutive. A page is 64 lines, so the page is the line address without its low 6 bits.
- R6: Prefetch requests carry the prefetch flag set to 1. They address the window lines in ascending order, at most one per cycle. A read request in the same cycle takes the memory port first.
- R7: The window holds limit+1 lines. It is cut so that it ends at the last line of the first seed's page.
- R8: The training flag clears on the cycle after the fill of the last outstanding window line is accepted.
- R9: With training done, a read of a filled window line gives hit_valid on the next cycle with that line's fill data. It issues no memory request.
- R10: Any read that does not hit is presented on the memory port on the next cycle with the same line and the prefetch flag 0. This includes every read made while the training flag is set.
- R11: A fill is ignored when it arrives while no prefetch window is being filled. Ignored means it changes no buffered data.
- R12: A limit of 31 gives a full 32-line window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Arm pulse: starts a new training sequence |
| cfg_limit | input | 5 | Window length minus one |
| cfg_three_seed | input | 1 | 1: three seed reads required, 0: two |
| train_mode | output | 1 | Training flag, clears by itself when the window is filled |
| rd_req_valid | input | 1 | Read request strobe |
| rd_req_line | input | 26 | Line address of the read |
| hit_valid | output | 1 | Read answered from the buffer |
| hit_line | output | 26 | Line address of the answered read |
| hit_data | output | 32 | Buffered line data |
| mem_req_valid | output | 1 | Memory request strobe |
| mem_req_line | output | 26 | Line address sent to memory |
| mem_req_pf | output | 1 | 1 for a prefetch, 0 for a forwarded read |
| mem_fill_valid | input | 1 | Prefetch fill strobe |
| mem_fill_line | input | 26 | Line address of the fill |
| mem_fill_data | input | 32 | Fill data |

## Verification
The bench uses the default parameters: 32 buffer entries, 64-line pages and 26-bit line addresses. With these values a limit of 31 makes a full window of 32 lines. A seed that starts four lines below a page end shows the window being cut short, and seeds that straddle a page edge show the restart. The memory model answers each prefetch in the same cycle it sees it. This makes the time from the last fill to the flag dropping exact to one cycle. A read held against a pending prefetch shows that reads take the memory port first.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
    typedef enum logic [1:0] {
        PF_IDLE  = 2'd0,
        PF_SEED  = 2'd1,
        PF_FETCH = 2'd2
    } pf_state_e;
endpackage

// File: rtl/pfe_stride_det.sv
module pfe_stride_det #(
    parameter int LINE_W = 26,
    parameter int POFF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              active,
    input  logic              three_seed,
    input  logic              req_valid,
    input  logic [LINE_W-1:0] req_line,
    output logic              found,
    output logic [LINE_W-1:0] first_line
);
    typedef struct packed {
        logic [LINE_W-1:0] first;
        logic [LINE_W-1:0] last;
        logic [1:0]        cnt;
    } det_t;

    det_t det_d, det_q;
    logic consec;
    logic [1:0] need;

    always_comb begin
        det_d  = det_q;
        found  = 1'b0;
        need   = three_seed ? 2'd3 : 2'd2;
        consec = (req_line == det_q.last + 1'b1) &&
                 (req_line[LINE_W-1:POFF_W] == det_q.last[LINE_W-1:POFF_W]);
        if (restart) begin
            det_d.cnt = 2'd0;
        end else if (active && req_valid) begin
            if (det_q.cnt != 2'd0 && consec) begin
                det_d.cnt  = det_q.cnt + 2'd1;
                det_d.last = req_line;
                if (det_q.cnt + 2'd1 == need) begin
                    found = 1'b1;
                end
            end else begin
                det_d.first = req_line;
                det_d.last  = req_line;
                det_d.cnt   = 2'd1;
            end
        end
    end

    assign first_line = det_q.first;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end
endmodule

// File: rtl/pfe_line_buf.sv
module pfe_line_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  chk_idx,
    output logic              chk_valid
);
    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (clear) begin
                buf_d.vld[i] = 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                buf_d.vld[i] = 1'b1;
                buf_d.mem[i] = wr_data;
            end
        end
    end

    assign rd_valid  = buf_q.vld[rd_idx];
    assign rd_data   = buf_q.mem[rd_idx];
    assign chk_valid = buf_q.vld[chk_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end
endmodule

// File: rtl/pfe_engine.sv
module pfe_engine #(
    parameter int LINE_W     = 26,
    parameter int DATA_W     = 32,
    parameter int MAX_LINES  = 32,
    parameter int PAGE_LINES = 64,
    localparam int IDX_W     = $clog2(MAX_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_limit,
    input  logic              cfg_three_seed,
    output logic              train_mode,
    input  logic              rd_req_valid,
    input  logic [LINE_W-1:0] rd_req_line,
    output logic              hit_valid,
    output logic [LINE_W-1:0] hit_line,
    output logic [DATA_W-1:0] hit_data,
    output logic              mem_req_valid,
    output logic [LINE_W-1:0] mem_req_line,
    output logic              mem_req_pf,
    input  logic              mem_fill_valid,
    input  logic [LINE_W-1:0] mem_fill_line,
    input  logic [DATA_W-1:0] mem_fill_data
);
    import pfe_pkg::*;

    localparam int POFF_W = $clog2(PAGE_LINES);
    localparam int TOT_W  = POFF_W + 1;

    typedef struct packed {
        pf_state_e         state;
        logic [IDX_W-1:0]  limit;
        logic              three;
        logic [LINE_W-1:0] base;
        logic [TOT_W-1:0]  total;
        logic [TOT_W-1:0]  issued;
        logic [TOT_W-1:0]  filled;
        logic              req_v;
        logic [LINE_W-1:0] req_line;
        logic              req_pf;
        logic              hit_v;
        logic [LINE_W-1:0] hit_line;
        logic [DATA_W-1:0] hit_data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              det_active, det_found;
    logic [LINE_W-1:0] det_first;
    logic [LINE_W-1:0] rd_diff, f_diff;
    logic              rd_inwin, buf_rd_vld, buf_chk_vld;
    logic [DATA_W-1:0] buf_rd_data;
    logic              hit, fill_acc;
    logic [TOT_W-1:0]  lim_len, room;

    assign det_active = (ctl_q.state == PF_SEED) && !cfg_we;
    assign rd_diff    = rd_req_line - ctl_q.base;
    assign f_diff     = mem_fill_line - ctl_q.base;
    assign rd_inwin   = rd_diff < LINE_W'(MAX_LINES);

    pfe_stride_det #(
        .LINE_W (LINE_W),
        .POFF_W (POFF_W)
    ) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (cfg_we),
        .active     (det_active),
        .three_seed (ctl_q.three),
        .req_valid  (rd_req_valid),
        .req_line   (rd_req_line),
        .found      (det_found),
        .first_line (det_first)
    );

    pfe_line_buf #(
        .DATA_W (DATA_W),
        .DEPTH  (MAX_LINES),
        .IDX_W  (IDX_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cfg_we),
        .wr_en     (fill_acc),
        .wr_idx    (f_diff[IDX_W-1:0]),
        .wr_data   (mem_fill_data),
        .rd_idx    (rd_diff[IDX_W-1:0]),
        .rd_valid  (buf_rd_vld),
        .rd_data   (buf_rd_data),
        .chk_idx   (f_diff[IDX_W-1:0]),
        .chk_valid (buf_chk_vld)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.req_v  = 1'b0;
        ctl_d.req_pf = 1'b0;
        ctl_d.hit_v  = 1'b0;

        lim_len  = TOT_W'(ctl_q.limit) + TOT_W'(1);
        room     = TOT_W'(PAGE_LINES) - TOT_W'(det_first[POFF_W-1:0]);
        hit      = (ctl_q.state == PF_IDLE) && !cfg_we && rd_req_valid &&
                   rd_inwin && buf_rd_vld;
        fill_acc = (ctl_q.state == PF_FETCH) && !cfg_we && mem_fill_valid &&
                   (f_diff < LINE_W'(ctl_q.total)) && !buf_chk_vld;

        if (rd_req_valid) begin
            if (hit) begin
                ctl_d.hit_v    = 1'b1;
                ctl_d.hit_line = rd_req_line;
                ctl_d.hit_data = buf_rd_data;
            end else begin
                ctl_d.req_v    = 1'b1;
                ctl_d.req_line = rd_req_line;
            end
        end

        if (cfg_we) begin
            ctl_d.state  = PF_SEED;
            ctl_d.limit  = cfg_limit;
            ctl_d.three  = cfg_three_seed;
            ctl_d.issued = '0;
            ctl_d.filled = '0;
        end else begin
            unique case (ctl_q.state)
                PF_SEED: begin
                    if (det_found) begin
                        ctl_d.base  = det_first;
                        ctl_d.total = (lim_len < room) ? lim_len : room;
                        ctl_d.state = PF_FETCH;
                    end
                end
                PF_FETCH: begin
                    if (!rd_req_valid && ctl_q.issued < ctl_q.total) begin
                        ctl_d.req_v    = 1'b1;
                        ctl_d.req_pf   = 1'b1;
                        ctl_d.req_line = ctl_q.base + LINE_W'(ctl_q.issued);
                        ctl_d.issued   = ctl_q.issued + TOT_W'(1);
                    end
                    if (fill_acc) begin
                        ctl_d.filled = ctl_q.filled + TOT_W'(1);
                        if (ctl_q.filled + TOT_W'(1) == ctl_q.total) begin
                            ctl_d.state = PF_IDLE;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= PF_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign train_mode    = (ctl_q.state != PF_IDLE);
    assign hit_valid     = ctl_q.hit_v;
    assign hit_line      = ctl_q.hit_line;
    assign hit_data      = ctl_q.hit_data;
    assign mem_req_valid = ctl_q.req_v;
    assign mem_req_line  = ctl_q.req_line;
    assign mem_req_pf    = ctl_q.req_pf;
endmodule

// File: rtl/pfe_engine_chk.sv
module pfe_engine_chk #(
    parameter int LINE_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              rd_req_valid,
    input logic [LINE_W-1:0] rd_req_line,
    input logic              train_mode,
    input logic              hit_valid,
    input logic              mem_req_valid,
    input logic [LINE_W-1:0] mem_req_line,
    input logic              mem_req_pf,
    input logic              mem_fill_valid
);
    p_arm_sets_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> train_mode);

    p_train_read_fwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && train_mode) |=>
            (mem_req_valid && !mem_req_pf && mem_req_line == $past(rd_req_line)));

    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |=> (hit_valid != (mem_req_valid && !mem_req_pf)));

    p_demand_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |=> !(mem_req_valid && mem_req_pf));

    p_pf_in_train_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_pf) |-> train_mode);

    p_done_after_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(train_mode) |-> $past(mem_fill_valid));

    p_no_spurious_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_pf) |-> $past(rd_req_valid));
endmodule

bind pfe_engine pfe_engine_chk #(.LINE_W(LINE_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we         (cfg_we),
    .rd_req_valid   (rd_req_valid),
    .rd_req_line    (rd_req_line),
    .train_mode     (train_mode),
    .hit_valid      (hit_valid),
    .mem_req_valid  (mem_req_valid),
    .mem_req_line   (mem_req_line),
    .mem_req_pf     (mem_req_pf),
    .mem_fill_valid (mem_fill_valid)
);

// File: tb/pfe_engine_tb_top.sv
module pfe_engine_tb_top;
    localparam int LINE_W = 26;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [IDX_W-1:0]  cfg_limit = '0;
    logic              cfg_three_seed = 1'b0;
    logic              train_mode;
    logic              rd_req_valid = 1'b0;
    logic [LINE_W-1:0] rd_req_line = '0;
    logic              hit_valid;
    logic [LINE_W-1:0] hit_line;
    logic [DATA_W-1:0] hit_data;
    logic              mem_req_valid;
    logic [LINE_W-1:0] mem_req_line;
    logic              mem_req_pf;
    logic              mem_fill_valid = 1'b0;
    logic [LINE_W-1:0] mem_fill_line = '0;
    logic [DATA_W-1:0] mem_fill_data = '0;

    always #4 clk = ~clk;

    pfe_engine dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_limit      (cfg_limit),
        .cfg_three_seed (cfg_three_seed),
        .train_mode     (train_mode),
        .rd_req_valid   (rd_req_valid),
        .rd_req_line    (rd_req_line),
        .hit_valid      (hit_valid),
        .hit_line       (hit_line),
        .hit_data       (hit_data),
        .mem_req_valid  (mem_req_valid),
        .mem_req_line   (mem_req_line),
        .mem_req_pf     (mem_req_pf),
        .mem_fill_valid (mem_fill_valid),
        .mem_fill_line  (mem_fill_line),
        .mem_fill_data  (mem_fill_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int last_fill_cyc = -10;
    bit prev_tm  = 1'b0;
    bit finished = 1'b0;

    logic [LINE_W:0]   exp_req_q[$];
    string             exp_req_tag[$];
    logic [LINE_W-1:0] exp_hit_q[$];
    string             exp_hit_tag[$];
    logic [LINE_W-1:0] pend_q[$];

    bit                man_req = 1'b0;
    logic [LINE_W-1:0] man_line = '0;
    logic [DATA_W-1:0] man_data = '0;

    function automatic logic [DATA_W-1:0] fdata(logic [LINE_W-1:0] l);
        return {l[15:0] ^ 16'h5A5A, l[15:0]};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor, scoreboard pop side and memory fill model
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_req_valid) begin
                if (exp_req_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected memory request", {mem_req_pf, mem_req_line}, 0);
                end else begin
                    logic [LINE_W:0] e;
                    string t;
                    e = exp_req_q.pop_front();
                    t = exp_req_tag.pop_front();
                    chk({mem_req_pf, mem_req_line} == e, t, "memory request {pf,line}",
                        {mem_req_pf, mem_req_line}, e);
                end
                if (mem_req_pf) pend_q.push_back(mem_req_line);
            end
            if (hit_valid) begin
                if (exp_hit_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected buffer hit", hit_line, 0);
                end else begin
                    logic [LINE_W-1:0] hl;
                    string t;
                    hl = exp_hit_q.pop_front();
                    t  = exp_hit_tag.pop_front();
                    chk(hit_line == hl, t, "hit line", hit_line, hl);
                    chk(hit_data == fdata(hl), t, "hit data", hit_data, fdata(hl));
                end
            end
            if (prev_tm && !train_mode) begin
                chk(cyc == last_fill_cyc + 1, "R8", "cycles from last fill to flag clear",
                    cyc - last_fill_cyc, 1);
            end
            prev_tm = train_mode;
            if (man_req) begin
                mem_fill_valid = 1'b1;
                mem_fill_line  = man_line;
                mem_fill_data  = man_data;
                man_req        = 1'b0;
            end else if (pend_q.size() > 0) begin
                logic [LINE_W-1:0] fl;
                fl = pend_q.pop_front();
                mem_fill_valid = 1'b1;
                mem_fill_line  = fl;
                mem_fill_data  = fdata(fl);
                last_fill_cyc  = cyc;
            end else begin
                mem_fill_valid = 1'b0;
            end
        end
    end

    task automatic rd(logic [LINE_W-1:0] line, bit exp_hit, string tag);
        if (exp_hit) begin
            exp_hit_q.push_back(line);
            exp_hit_tag.push_back(tag);
        end else begin
            exp_req_q.push_back({1'b0, line});
            exp_req_tag.push_back(tag);
        end
        rd_req_valid = 1'b1;
        rd_req_line  = line;
        @(negedge clk);
        rd_req_valid = 1'b0;
    endtask

    task automatic exp_pf(logic [LINE_W-1:0] base, int n, string tag);
        for (int i = 0; i < n; i++) begin
            exp_req_q.push_back({1'b1, base + LINE_W'(i)});
            exp_req_tag.push_back(tag);
        end
    endtask

    task automatic arm(int limit, bit three);
        cfg_we         = 1'b1;
        cfg_limit      = IDX_W'(limit);
        cfg_three_seed = three;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(train_mode == 1'b1, "R2", "training flag after arm", train_mode, 1);
    endtask

    task automatic wait_done(string tag);
        int n = 0;
        while (train_mode && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(train_mode == 1'b0, tag, "training completes", train_mode, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(train_mode == 1'b0, "R1", "training flag", train_mode, 0);
        chk(mem_req_valid == 1'b0, "R1", "memory request", mem_req_valid, 0);
        chk(hit_valid == 1'b0, "R1", "hit", hit_valid, 0);

        // R10: read before any training is forwarded
        rd(26'h200, 1'b0, "R10");
        drain();

        // R3 two seeds, R6 ascending prefetch, R9 hits, R8 completion
        arm(7, 1'b0);
        rd(26'h100, 1'b0, "R10");
        rd(26'h101, 1'b0, "R3");
        exp_pf(26'h100, 8, "R6");
        wait_done("R8");
        for (int i = 0; i < 8; i++) rd(26'h100 + LINE_W'(i), 1'b1, "R9");
        rd(26'h108, 1'b0, "R10");
        drain();

        // R3 three seeds with a break: R4 restart
        arm(3, 1'b1);
        rd(26'h300, 1'b0, "R3");
        rd(26'h301, 1'b0, "R3");
        rd(26'h305, 1'b0, "R4");
        rd(26'h306, 1'b0, "R4");
        rd(26'h307, 1'b0, "R3");
        exp_pf(26'h305, 4, "R4");
        wait_done("R4");
        rd(26'h305, 1'b1, "R4");
        rd(26'h308, 1'b1, "R4");
        rd(26'h300, 1'b0, "R4");
        drain();

        // R5 page edge breaks the stride
        arm(3, 1'b0);
        rd(26'h43F, 1'b0, "R5");
        rd(26'h440, 1'b0, "R5");
        rd(26'h441, 1'b0, "R5");
        exp_pf(26'h440, 4, "R5");
        wait_done("R5");
        rd(26'h440, 1'b1, "R5");
        drain();

        // R7 window cut at page end
        arm(7, 1'b0);
        rd(26'h53C, 1'b0, "R7");
        rd(26'h53D, 1'b0, "R7");
        exp_pf(26'h53C, 4, "R7");
        wait_done("R7");
        rd(26'h53F, 1'b1, "R7");
        rd(26'h540, 1'b0, "R7");
        drain();

        // R2 re-arm invalidates overlapping entries
        arm(7, 1'b0);
        rd(26'h600, 1'b0, "R2");
        rd(26'h601, 1'b0, "R2");
        exp_pf(26'h600, 8, "R2");
        wait_done("R2");
        arm(1, 1'b0);
        rd(26'h604, 1'b0, "R2");
        rd(26'h605, 1'b0, "R2");
        exp_pf(26'h604, 2, "R2");
        wait_done("R2");
        rd(26'h606, 1'b0, "R2");
        rd(26'h605, 1'b1, "R2");
        drain();

        // R12 full 32-line window
        arm(31, 1'b0);
        rd(26'h700, 1'b0, "R12");
        rd(26'h701, 1'b0, "R12");
        exp_pf(26'h700, 32, "R12");
        wait_done("R12");
        rd(26'h71F, 1'b1, "R12");
        rd(26'h700, 1'b1, "R12");
        rd(26'h720, 1'b0, "R12");
        drain();

        // R6 read beats a pending prefetch; R10 read during training forwarded
        arm(3, 1'b0);
        rd(26'h800, 1'b0, "R6");
        rd(26'h801, 1'b0, "R6");
        rd(26'h900, 1'b0, "R10");
        exp_pf(26'h800, 4, "R6");
        wait_done("R6");
        drain();

        // R11 stray fill while idle is ignored
        man_line = 26'h801;
        man_data = 32'hDEADBEEF;
        man_req  = 1'b1;
        repeat (3) @(negedge clk);
        rd(26'h801, 1'b1, "R11");
        drain();

        chk(exp_req_q.size() == 0, "R6", "outstanding expected requests", exp_req_q.size(), 0);
        chk(exp_hit_q.size() == 0, "R9", "outstanding expected hits", exp_hit_q.size(), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule